// File: doc/BRIEF.md
# Boundary Scan Register

This block is the pin-side scan register of a test access port. It serves a parameterised number of bidirectional pins and input-only pins. For each bidirectional pin it keeps three one-bit shift stages, one for output data, one for output enable and one for pad input. It also keeps two holding stages, one for drive data and one for drive enable. An input-only pin adds one stage. All stages form a single serial chain from `tdi` to `tdo`.

The TAP state machine supplies the capture, shift and update strobes and two decoded instruction selects. The chain responds only while one of those selects is active: the sample/preload select or the external-test select.

In normal operation the core's output data and enable reach the pads unchanged, and pad inputs reach the core unchanged. When the external-test select is active, the pad drive comes from the holding stages. Pads are modelled as separate in, out and enable signals. Everything runs on the test clock with a synchronous active-high reset.

Top module: `bscan_register`

## Requirements
- R1: While `rst` is high, every shift stage and every holding stage clears on the next clock edge. As a result `tdo` reads 0, and under external test every pad is driven 0 with its enable 0.
- R2: A capture strobe while the chain is selected loads the live pin values into the chain. Bidirectional pin k loads `core_do[k]` at chain index 3k, `core_oe[k]` at 3k+1 and `pad_di[k]` at 3k+2. Input-only pin j loads `ionly_di[j]` at index 3*NB+j. Index 0 is the stage nearest `tdo`.
- R3: A shift strobe while the chain is selected moves every stage one index toward `tdo` and loads `tdi` at the top index, 3*NB+NI-1. `tdo` always shows index 0, so a bit entered at `tdi` reaches `tdo` after exactly 3*NB+NI shifts.
- R4: The holding stages of pin k load chain indices 3k (data) and 3k+1 (enable) only on an update strobe while the chain is selected. Capture and shift cycles leave them, and hence the external-test pad drive, unchanged.
- R5: While `ir_extest` is high, `pad_do`/`pad_oe` equal the holding stages. Otherwise they equal `core_do`/`core_oe`.
- R6: Under sample/preload alone, capture, shift and update never change `pad_do` or `pad_oe`, which keep following the core, while the holding stages are still preloaded.
- R7: With neither instruction select high, capture, shift and update strobes are ignored: chain contents and holding stages stay as they were.
- R8: `core_di` always equals `pad_di` and `core_ionly_di` always equals `ionly_di`, whatever the instruction.
- R9: If several strobes are high in one cycle, capture takes precedence over shift, and shift over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| ir_sample | input | 1 | Sample/preload instruction decoded |
| ir_extest | input | 1 | External-test instruction decoded |
| core_do | input | NB | Core output data per bidirectional pin |
| core_oe | input | NB | Core output enable per bidirectional pin |
| pad_di | input | NB | Pad input value per bidirectional pin |
| ionly_di | input | NI | Pad value of input-only pins |
| pad_do | output | NB | Data driven to pads |
| pad_oe | output | NB | Enable driven to pads |
| core_di | output | NB | Pad input passed to the core |
| core_ionly_di | output | NI | Input-only pad value passed to the core |
| tdo | output | 1 | Serial scan output |

## Verification
The bench builds the block with four bidirectional pins and two input-only pins, a 14-stage chain. At that size every stage can be captured, read bit by bit at `tdo` and overwritten within a few dozen cycles. The index of each cell type, the exact shift-through latency, and the boundary between the last bidirectional cell and the first input-only cell are all checked on every pass. The small chain also allows many random capture/preload/external-test rounds, plus the directed cases for deselected strobes and colliding strobes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // Stages kept in the chain for one bidirectional pin.
    localparam int unsigned STAGES_PER_BIDIR = 3;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_CAPTURE,
        BS_SHIFT,
        BS_UPDATE
    } bs_op_e;

    // Per-pin sampled/shifted triple; field order fixes chain order
    typedef struct packed {
        logic dout;
        logic oe;
        logic din;
    } bs_triple_t;

    // Pad drive pair (data and enable)
    typedef struct packed {
        logic dout;
        logic oe;
    } bs_drive_t;

    function automatic int unsigned chain_len(input int unsigned nb, input int unsigned ni);
        return STAGES_PER_BIDIR * nb + ni;
    endfunction

    // Resolve strobes into one operation; capture beats shift beats update.
    function automatic bs_op_e decode_op(input logic chain_sel, input logic cap,
                                         input logic sh, input logic upd);
        bs_op_e op;
        if (!chain_sel)  op = BS_IDLE;
        else if (cap)    op = BS_CAPTURE;
        else if (sh)     op = BS_SHIFT;
        else if (upd)    op = BS_UPDATE;
        else             op = BS_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/bs_bidir_cell.sv
module bs_bidir_cell
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bs_op_e     op,
    input  logic       scan_in,
    input  bs_triple_t live,
    output logic       scan_out,
    output bs_drive_t  held
);

    bs_triple_t stg;

    // Shift stages: din is nearest scan_in, dout nearest scan_out.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            case (op)
                BS_CAPTURE: stg <= live;
                BS_SHIFT:   stg <= '{dout: stg.oe, oe: stg.din, din: scan_in};
                default:    stg <= stg;
            endcase
        end
    end

    // Holding stages load only on update, so the drive stays calm while shifting.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (op == BS_UPDATE) begin
            held <= '{dout: stg.dout, oe: stg.oe};
        end
    end

    assign scan_out = stg.dout;

    a_r1_bidir_reset_clears: assert property (@(posedge clk)
        rst |=> (stg == '0 && held == '0));

    a_r2_bidir_capture_live: assert property (@(posedge clk) disable iff (rst)
        (op == BS_CAPTURE) |=> (stg == $past(live)));

    a_r3_bidir_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (op == BS_SHIFT) |=> (stg.dout == $past(stg.oe) && stg.din == $past(scan_in)));

    a_r4_hold_only_on_update: assert property (@(posedge clk) disable iff (rst)
        (op != BS_UPDATE) |=> $stable(held));

    a_r7_bidir_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == BS_IDLE) |=> $stable(stg));

endmodule

// File: rtl/bs_input_cell.sv
module bs_input_cell
    import bscan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  bs_op_e op,
    input  logic   scan_in,
    input  logic   live,
    output logic   scan_out
);

    logic stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= 1'b0;
        end else begin
            case (op)
                BS_CAPTURE: stg <= live;
                BS_SHIFT:   stg <= scan_in;
                default:    stg <= stg;
            endcase
        end
    end

    assign scan_out = stg;

    a_r2_input_capture_live: assert property (@(posedge clk) disable iff (rst)
        (op == BS_CAPTURE) |=> (stg == $past(live)));

    a_r7_input_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == BS_IDLE) |=> $stable(stg));

endmodule

// File: rtl/bs_pad_mux.sv
module bs_pad_mux
    import bscan_pkg::*;
(
    input  logic      extest,
    input  bs_drive_t core,
    input  bs_drive_t held,
    output bs_drive_t pad
);

    always_comb begin
        pad = extest ? held : core;
    end

endmodule

// File: rtl/bscan_register.sv
module bscan_register
    import bscan_pkg::*;
#(
    parameter int unsigned NB = 8,
    parameter int unsigned NI = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tdi,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          ir_sample,
    input  logic          ir_extest,
    input  logic [NB-1:0] core_do,
    input  logic [NB-1:0] core_oe,
    input  logic [NB-1:0] pad_di,
    input  logic [NI-1:0] ionly_di,
    output logic [NB-1:0] pad_do,
    output logic [NB-1:0] pad_oe,
    output logic [NB-1:0] core_di,
    output logic [NI-1:0] core_ionly_di,
    output logic          tdo
);

    // One link per pin unit; unit u reads link[u+1] and drives link[u].
    localparam int unsigned NUNITS = NB + NI;

    logic      chain_sel;
    bs_op_e    op;
    logic [NUNITS:0] link;

    assign chain_sel = ir_sample | ir_extest;
    assign op        = decode_op(chain_sel, capture_dr, shift_dr, update_dr);
    assign link[NUNITS] = tdi;
    assign tdo          = link[0];

    assign core_di       = pad_di;
    assign core_ionly_di = ionly_di;

    for (genvar k = 0; k < NB; k++) begin : g_bidir
        bs_drive_t held_k;
        bs_drive_t pad_k;

        bs_bidir_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .op       (op),
            .scan_in  (link[k+1]),
            .live     ('{dout: core_do[k], oe: core_oe[k], din: pad_di[k]}),
            .scan_out (link[k]),
            .held     (held_k)
        );

        bs_pad_mux u_mux (
            .extest (ir_extest),
            .core   ('{dout: core_do[k], oe: core_oe[k]}),
            .held   (held_k),
            .pad    (pad_k)
        );

        assign pad_do[k] = pad_k.dout;
        assign pad_oe[k] = pad_k.oe;
    end

    for (genvar j = 0; j < NI; j++) begin : g_inonly
        bs_input_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .op       (op),
            .scan_in  (link[NB+j+1]),
            .live     (ionly_di[j]),
            .scan_out (link[NB+j])
        );
    end

    a_r1_tdo_low_after_reset: assert property (@(posedge clk)
        rst |=> !tdo);

    a_r5_drive_follows_core: assert property (@(posedge clk) disable iff (rst)
        !ir_extest |-> (pad_do == core_do && pad_oe == core_oe));

    a_r6_sample_keeps_drive: assert property (@(posedge clk) disable iff (rst)
        (!ir_extest && $past(!ir_extest) && $stable(core_do) && $stable(core_oe))
            |-> ($stable(pad_do) && $stable(pad_oe)));

endmodule

// File: tb/bscan_register_tb.sv
module bscan_register_tb;

    localparam int  NB = 4;
    localparam int  NI = 2;
    localparam int  L  = 3 * NB + NI;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tdi = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic ir_sample = 1'b0, ir_extest = 1'b0;
    logic [NB-1:0] core_do = '0, core_oe = '0, pad_di = '0;
    logic [NI-1:0] ionly_di = '0;
    logic [NB-1:0] pad_do, pad_oe, core_di;
    logic [NI-1:0] core_ionly_di;
    logic tdo;

    int nvec = 0;
    int nerr = 0;
    logic [NB-1:0] hold_do = '0, hold_oe = '0;

    always #(PERIOD/2) clk = ~clk;

    bscan_register #(.NB(NB), .NI(NI)) u_dut (
        .clk(clk), .rst(rst), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .ir_sample(ir_sample), .ir_extest(ir_extest),
        .core_do(core_do), .core_oe(core_oe), .pad_di(pad_di), .ionly_di(ionly_di),
        .pad_do(pad_do), .pad_oe(pad_oe), .core_di(core_di),
        .core_ionly_di(core_ionly_di), .tdo(tdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply strobes for one clock edge; inputs change at the falling edge.
    task automatic pulse(input logic c, input logic s, input logic u, input logic t);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = t;
        @(posedge clk);
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    endtask

    // Chain image expected after a capture of the current pin values (R2).
    function automatic logic [L-1:0] exp_cap();
        logic [L-1:0] v;
        for (int k = 0; k < NB; k++) begin
            v[3*k]   = core_do[k];
            v[3*k+1] = core_oe[k];
            v[3*k+2] = pad_di[k];
        end
        for (int j = 0; j < NI; j++) v[3*NB+j] = ionly_di[j];
        return v;
    endfunction

    // Read the whole chain at tdo while loading a new image.
    task automatic scan(input logic [L-1:0] expect_out, input logic [L-1:0] load, input string req);
        for (int i = 0; i < L; i++) begin
            chk(req, {31'd0, tdo}, {31'd0, expect_out[i]});
            pulse(1'b0, 1'b1, 1'b0, load[i]);
        end
    endtask

    task automatic preload_holds(input logic [L-1:0] img);
        for (int k = 0; k < NB; k++) begin
            hold_do[k] = img[3*k];
            hold_oe[k] = img[3*k+1];
        end
    endtask

    task automatic chk_drive(input string req);
        if (ir_extest) begin
            chk(req, {28'd0, pad_do}, {28'd0, hold_do});
            chk(req, {28'd0, pad_oe}, {28'd0, hold_oe});
        end else begin
            chk(req, {28'd0, pad_do}, {28'd0, core_do});
            chk(req, {28'd0, pad_oe}, {28'd0, core_oe});
        end
    endtask

    task automatic randomize_pins();
        core_do  = NB'($urandom);
        core_oe  = NB'($urandom);
        pad_di   = NB'($urandom);
        ionly_di = NI'($urandom);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        nvec++;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [L-1:0] cap, img, img2;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: cleared chain and holds
        chk("R1 tdo", {31'd0, tdo}, 32'd0);
        ir_extest = 1'b1;
        core_do = '1; core_oe = '1;
        #1;
        chk("R1 pad_do under extest", {28'd0, pad_do}, 32'd0);
        chk("R1 pad_oe under extest", {28'd0, pad_oe}, 32'd0);
        ir_extest = 1'b0;
        #1;
        chk_drive("R5 functional pass");

        // Random capture / preload / external-test rounds
        for (int it = 0; it < 8; it++) begin
            randomize_pins();
            ir_sample = 1'b1;
            #1;
            chk("R8 core_di", {28'd0, core_di}, {28'd0, pad_di});
            chk("R8 core_ionly_di", {30'd0, core_ionly_di}, {30'd0, ionly_di});
            chk_drive("R6 before capture");
            cap = exp_cap();
            pulse(1'b1, 1'b0, 1'b0, 1'b0);
            img = L'($urandom);
            scan(cap, img, "R2 R3 captured bit at tdo");
            chk_drive("R6 after shift");
            pulse(1'b0, 1'b0, 1'b1, 1'b0);
            preload_holds(img);
            chk_drive("R6 after update");
            ir_sample = 1'b0;
            ir_extest = 1'b1;
            #1;
            chk_drive("R5 extest drive");
            for (int s = 0; s < 5; s++) pulse(1'b0, 1'b1, 1'b0, 1'($urandom));
            core_do = ~core_do;
            pulse(1'b1, 1'b0, 1'b0, 1'b0);
            chk_drive("R4 holds stable across shift/capture");
            ir_extest = 1'b0;
        end

        // R3: exact latency of a single one through a zeroed chain
        core_do = '0; core_oe = '0; pad_di = '0; ionly_di = '0;
        ir_sample = 1'b1;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0, 1'b1);
        for (int s = 1; s < L; s++) begin
            chk("R3 not yet at tdo", {31'd0, tdo}, 32'd0);
            pulse(1'b0, 1'b1, 1'b0, 1'b0);
        end
        chk("R3 arrives after L shifts", {31'd0, tdo}, 32'd1);

        // R7: strobes ignored when deselected
        randomize_pins();
        cap = exp_cap();
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        ir_sample = 1'b0;
        core_do = ~core_do; pad_di = ~pad_di;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        ir_extest = 1'b1;
        #1;
        chk_drive("R7 holds untouched");
        ir_extest = 1'b0;
        ir_sample = 1'b1;
        img = L'($urandom);
        scan(cap, img, "R7 chain untouched");

        // R9: capture wins over shift; shift wins over update
        randomize_pins();
        cap = exp_cap();
        pulse(1'b1, 1'b1, 1'b0, 1'b1);
        img2 = L'($urandom);
        scan(cap, img2, "R9 capture beats shift");
        pulse(1'b0, 1'b1, 1'b1, 1'b0);
        ir_sample = 1'b0;
        ir_extest = 1'b1;
        #1;
        chk_drive("R9 shift beats update");
        ir_extest = 1'b0;

        finish_run();
    end

endmodule